// File: doc/BRIEF.md
# Lock-in Detector Measurement Sequencer

This block is the digital sequencer for a chopper-stabilised synchronous detector that works with an external analog integrator. During integration it switches the input into the integrator between the direct path and the inverted path with two complementary 1 kHz phase outputs. The analog side therefore rectifies only the component that is locked to the reference and averages everything else away. After a fixed number of chopping periods it turns on a constant-current discharge and times the ramp with a single-slope counter. The counter stops at the first synchronized change of an external comparator or at a hard cap. The block then clamps the integrator for a fixed settling interval and starts the next cycle.

The default timing assumes an 8 MHz clock. A prescaler gives a conversion step every 10 clocks (1.25 us) and a slot tick every 200 steps (250 us). One chopping period is four slot ticks. The conversion takes one whole slot. The 7-bit result is published with a one-clock strobe at the start of the clamp. A threshold indicator holds the comparison of that result against a fixed level for the whole following cycle. A self-test output carries bursts in step with the first phase on every other cycle, so a heavily attenuated copy can be fed back as a known input.

Top module: `lockin_sequencer`

## Requirements
- R1: At most one of phase_a_o, phase_b_o, discharge_o and clamp_o is high in any clock. When control passes from one of them to another, all four are low for at least one clock between them.
- R2: While chopping, each period is 2*TICKS_PER_HALF slot ticks. phase_a_o is requested for the first half and phase_b_o for the second half. Because of the R1 gap, each output is high for TICKS_PER_HALF*TICK_SUBDIV*CONV_DIV - 1 clocks per half period.
- R3: Exactly INTEG_CYCLES chopping periods (default 999) run between clamp release and the start of conversion. Both phase outputs stay low during conversion and clamp.
- R4: The conversion counter starts at 0 on the conversion slot tick and adds one on every conversion step. It stops on the first change, in either direction, of the comparator after two synchronizer flops. With a conversion step on every clock, a comparator change applied d clocks after discharge_o is first seen high gives result_o = d+4.
- R5: The counter saturates and stops at 127 if the comparator does not change. result_o is 7 bits.
- R6: discharge_o goes high in the conversion slot and drops once counting stops. With a conversion step on every clock it is high for exactly result_o clocks.
- R7: At the slot tick that ends conversion, result_valid_o pulses for one clock with the new result_o. result_o holds until the next pulse. clamp_o is then requested for CLAMP_TICKS slot ticks (high for CLAMP_TICKS*TICK_SUBDIV*CONV_DIV - 1 clocks).
- R8: led_o is set at each result_valid_o pulse to (result_o > 64) and holds that value until the next pulse. A result of 64 turns it off and 65 turns it on.
- R9: On the first cycle after reset and every second cycle after that, test_o is high exactly when phase_a_o is high. On the other cycles test_o stays low.
- R10: While rst_n is low and after its release until the first chopping period, clamp_o is high. All other outputs, result_o included, are 0 while rst_n is low.
- R11: The interval between consecutive result_valid_o pulses is (4*INTEG_CYCLES... more precisely 2*TICKS_PER_HALF*INTEG_CYCLES + CLAMP_TICKS + 1) slot ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (8 MHz by default) |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_i | input | 1 | Asynchronous ramp comparator |
| phase_a_o | output | 1 | Enables the direct path into the integrator |
| phase_b_o | output | 1 | Enables the inverted path into the integrator |
| discharge_o | output | 1 | Enables the constant-current discharge |
| clamp_o | output | 1 | Clamps the integrator to its reference |
| result_o | output | 7 | Latest conversion count |
| result_valid_o | output | 1 | One-clock strobe with a new result |
| led_o | output | 1 | Result above threshold, held for one cycle |
| test_o | output | 1 | Self-test burst, in step with phase_a_o on alternate cycles |

## Verification
The hardest cases to reach are the exact stop count and the cap boundary. In both, the comparator change has to land on a known clock relative to the discharge start, across a two-flop synchronizer and an output gap. The bench sets the conversion step to every clock and watches discharge_o. It toggles cmp_i a chosen number of clocks after the first high sample, which places results at 4, 64, 65, 126 and 14. It also leaves one conversion without a change, to reach the 127 cap. Consecutive cycles toggle the comparator in opposite directions, so both edge polarities stop the count. The alternating self-test bursts are checked over several whole cycles.

// File: rtl/lis_pkg.sv
// Shared types for the lock-in sequencer.
// Assumes: one drive request is active at a time.
package lis_pkg;
    typedef enum logic [2:0] {
        DRV_OFF   = 3'd0,
        DRV_PA    = 3'd1,
        DRV_PB    = 3'd2,
        DRV_DIS   = 3'd3,
        DRV_CLAMP = 3'd4
    } drive_e;

    typedef enum logic [1:0] {
        ST_CLAMP = 2'd0,
        ST_CHOP  = 2'd1,
        ST_CONV  = 2'd2
    } seq_e;
endpackage

// File: rtl/lis_prescaler.sv
// Two-level prescaler: a conversion step every CONV_DIV clocks and a slot
// tick every TICK_SUBDIV steps. Both are single-clock enables.
// Assumes: CONV_DIV >= 1, TICK_SUBDIV >= 2.
module lis_prescaler #(
    parameter int CONV_DIV    = 10,
    parameter int TICK_SUBDIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic conv_tick,
    output logic main_tick
);
    localparam int DIV_W = (CONV_DIV > 1) ? $clog2(CONV_DIV) : 1;
    localparam int SUB_W = $clog2(TICK_SUBDIV);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CONV_DIV - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICK_SUBDIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [SUB_W-1:0] sub_q;

    assign conv_tick = (div_q == DIV_LAST);
    assign main_tick = conv_tick && (sub_q == SUB_LAST);

    // Advance the clock divider and the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            sub_q <= '0;
        end else begin
            div_q <= conv_tick ? '0 : div_q + 1'b1;
            if (conv_tick)
                sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
        end
    end
endmodule

// File: rtl/lis_sync.sv
// Brings the asynchronous comparator into the clock domain through STAGES
// flops and flags a change of the synchronized level.
// Assumes: STAGES >= 2.
module lis_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);
    logic [STAGES-1:0] pipe_q;
    logic              last_q;

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], async_i};
    end

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= pipe_q[STAGES-1];
    end

    assign edge_o = pipe_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/lis_ramp_counter.sv
// Single-slope timer: cleared and armed by start, counts conversion steps,
// stops on a comparator edge (priority) or at the all-ones cap.
// Assumes: start arrives only while idle.
module lis_ramp_counter #(
    parameter int RES_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             conv_tick,
    input  logic             cmp_edge,
    output logic [RES_W-1:0] count,
    output logic             running
);
    localparam logic [RES_W-1:0] CAP = '1;

    // Arm, count and stop the ramp measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
        end else if (start) begin
            count   <= '0;
            running <= 1'b1;
        end else if (running) begin
            if (cmp_edge)
                running <= 1'b0;
            else if (conv_tick) begin
                if (count == CAP) running <= 1'b0;
                else              count   <= count + 1'b1;
            end
        end
    end

    assert_edge_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cmp_edge && !start) |=> (!running && $stable(count)));

    assert_cap_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cmp_edge && conv_tick && count == CAP && !start)
        |=> (!running && count == CAP));
endmodule

// File: rtl/lis_driver.sv
// Registered output stage: turns a drive request into the four switch
// enables. Any change of request gives one all-off clock first.
// Assumes: requests come from registered state.
module lis_driver
    import lis_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  drive_e req,
    input  logic   burst_en,
    output logic   phase_a_o,
    output logic   phase_b_o,
    output logic   discharge_o,
    output logic   clamp_o,
    output logic   test_o
);
    drive_e prev_q;
    logic   steady;

    assign steady = (req == prev_q);

    // Register the enables, with a gap clock on every change of request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= DRV_CLAMP;
            phase_a_o   <= 1'b0;
            phase_b_o   <= 1'b0;
            discharge_o <= 1'b0;
            clamp_o     <= 1'b1;
            test_o      <= 1'b0;
        end else begin
            prev_q      <= req;
            phase_a_o   <= steady && (req == DRV_PA);
            phase_b_o   <= steady && (req == DRV_PB);
            discharge_o <= steady && (req == DRV_DIS);
            clamp_o     <= steady && (req == DRV_CLAMP);
            test_o      <= steady && (req == DRV_PA) && burst_en;
        end
    end

    assert_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phase_a_o, phase_b_o, discharge_o, clamp_o}));

    assert_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past({phase_a_o, phase_b_o, discharge_o, clamp_o}) != 4'b0 &&
         {phase_a_o, phase_b_o, discharge_o, clamp_o} != 4'b0)
        |-> $stable({phase_a_o, phase_b_o, discharge_o, clamp_o}));
endmodule

// File: rtl/lockin_sequencer.sv
// Lock-in detector sequencer: chops for INTEG_CYCLES periods, runs one
// single-slope conversion slot, publishes the result and clamps for
// CLAMP_TICKS slots. The reset state is clamp.
// Assumes: a capped conversion fits inside one slot
// (2^RES_W * CONV_DIV < TICK_SUBDIV * CONV_DIV).
module lockin_sequencer
    import lis_pkg::*;
#(
    parameter int CONV_DIV       = 10,
    parameter int TICK_SUBDIV    = 200,
    parameter int TICKS_PER_HALF = 2,
    parameter int INTEG_CYCLES   = 999,
    parameter int CLAMP_TICKS    = 4,
    parameter int RES_W          = 7,
    parameter int LED_LEVEL      = 64,
    parameter int SYNC_STAGES    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_i,
    output logic             phase_a_o,
    output logic             phase_b_o,
    output logic             discharge_o,
    output logic             clamp_o,
    output logic [RES_W-1:0] result_o,
    output logic             result_valid_o,
    output logic             led_o,
    output logic             test_o
);
    localparam int TPC   = 2 * TICKS_PER_HALF;
    localparam int TPC_W = (TPC > 1) ? $clog2(TPC) : 1;
    localparam int CYC_W = $clog2(INTEG_CYCLES + 1);
    localparam int CLP_W = $clog2(CLAMP_TICKS + 1);
    localparam logic [TPC_W-1:0] TPC_LAST  = TPC_W'(TPC - 1);
    localparam logic [TPC_W-1:0] HALF_MARK = TPC_W'(TICKS_PER_HALF);
    localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(INTEG_CYCLES - 1);
    localparam logic [CLP_W-1:0] CLP_LAST  = CLP_W'(CLAMP_TICKS - 1);
    localparam logic [RES_W-1:0] LED_THR   = RES_W'(LED_LEVEL);

    logic             conv_tick, main_tick, cmp_edge, conv_start, running;
    logic [RES_W-1:0] count;
    seq_e             state_q;
    logic [TPC_W-1:0] tick_in_q;
    logic [CYC_W-1:0] cyc_q;
    logic [CLP_W-1:0] clp_q;
    logic             burst_q;
    drive_e           req;

    lis_prescaler #(.CONV_DIV(CONV_DIV), .TICK_SUBDIV(TICK_SUBDIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .main_tick(main_tick));

    lis_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(cmp_i), .edge_o(cmp_edge));

    lis_ramp_counter #(.RES_W(RES_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .start(conv_start), .conv_tick(conv_tick),
        .cmp_edge(cmp_edge), .count(count), .running(running));

    assign conv_start = main_tick && (state_q == ST_CHOP) &&
                        (tick_in_q == TPC_LAST) && (cyc_q == CYC_LAST);

    // Step the clamp / chop / convert sequence on slot ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_CLAMP;
            tick_in_q      <= '0;
            cyc_q          <= '0;
            clp_q          <= '0;
            burst_q        <= 1'b0;
            result_o       <= '0;
            result_valid_o <= 1'b0;
            led_o          <= 1'b0;
        end else begin
            result_valid_o <= 1'b0;
            if (main_tick) begin
                unique case (state_q)
                    ST_CLAMP: begin
                        if (clp_q == CLP_LAST) begin
                            clp_q     <= '0;
                            tick_in_q <= '0;
                            cyc_q     <= '0;
                            burst_q   <= ~burst_q;
                            state_q   <= ST_CHOP;
                        end else begin
                            clp_q <= clp_q + 1'b1;
                        end
                    end
                    ST_CHOP: begin
                        if (tick_in_q == TPC_LAST) begin
                            tick_in_q <= '0;
                            if (cyc_q == CYC_LAST) begin
                                cyc_q   <= '0;
                                state_q <= ST_CONV;
                            end else begin
                                cyc_q <= cyc_q + 1'b1;
                            end
                        end else begin
                            tick_in_q <= tick_in_q + 1'b1;
                        end
                    end
                    ST_CONV: begin
                        state_q        <= ST_CLAMP;
                        result_o       <= count;
                        result_valid_o <= 1'b1;
                        led_o          <= (count > LED_THR);
                    end
                    default: state_q <= ST_CLAMP;
                endcase
            end
        end
    end

    // Pick the switch that the current state asks for.
    always_comb begin
        unique case (state_q)
            ST_CHOP: req = (tick_in_q < HALF_MARK) ? DRV_PA : DRV_PB;
            ST_CONV: req = running ? DRV_DIS : DRV_OFF;
            default: req = DRV_CLAMP;
        endcase
    end

    lis_driver u_drv (
        .clk(clk), .rst_n(rst_n), .req(req), .burst_en(burst_q),
        .phase_a_o(phase_a_o), .phase_b_o(phase_b_o),
        .discharge_o(discharge_o), .clamp_o(clamp_o), .test_o(test_o));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid_o |-> $stable(result_o));

    assert_led_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_o) |-> result_valid_o);

    assert_test_follows_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        test_o |-> phase_a_o);

    assert_no_phase_in_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && $past(state_q) == ST_CONV) |-> !(phase_a_o || phase_b_o));
endmodule

// File: tb/lockin_sequencer_tb.sv
module lockin_sequencer_tb;
    localparam int SUB   = 200;
    localparam int HALF  = 2;
    localparam int NCYC  = 3;
    localparam int CLT   = 4;
    localparam int HALF_CLKS  = HALF * SUB - 1;
    localparam int PHASE_TOT  = NCYC * HALF_CLKS;
    localparam int CLAMP_CLKS = CLT * SUB - 1;
    localparam int PERIOD     = (2 * HALF * NCYC + CLT + 1) * SUB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp = 1'b0;
    logic       pa, pb, dis, clp, valid, led, tst;
    logic [6:0] res;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc_idx  = 0;
    bit led_exp  = 1'b0;

    int c_a, c_b, c_clamp, c_test, c_bad, c_over, c_per;
    int s_a, s_b, s_clamp, s_test, s_bad, s_over, s_per;

    always #2 clk = ~clk;

    lockin_sequencer #(
        .CONV_DIV(1), .TICK_SUBDIV(SUB), .TICKS_PER_HALF(HALF),
        .INTEG_CYCLES(NCYC), .CLAMP_TICKS(CLT), .RES_W(7),
        .LED_LEVEL(64), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp),
        .phase_a_o(pa), .phase_b_o(pb), .discharge_o(dis), .clamp_o(clp),
        .result_o(res), .result_valid_o(valid), .led_o(led), .test_o(tst));

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Per-window output statistics, snapshotted at each result strobe.
    always @(negedge clk) begin
        if (!rst_n) begin
            c_a = 0; c_b = 0; c_clamp = 0; c_test = 0; c_bad = 0; c_over = 0; c_per = 0;
        end else begin
            if (valid) begin
                s_a = c_a; s_b = c_b; s_clamp = c_clamp; s_test = c_test;
                s_bad = c_bad; s_over = c_over; s_per = c_per;
                c_a = 0; c_b = 0; c_clamp = 0; c_test = 0; c_bad = 0; c_over = 0; c_per = 0;
            end
            c_per++;
            if (pa) c_a++;
            if (pb) c_b++;
            if (clp) c_clamp++;
            if (tst) c_test++;
            if (tst && !pa) c_bad++;
            if ((32'(pa) + 32'(pb) + 32'(dis) + 32'(clp)) > 1) c_over++;
        end
    end

    // R10: outputs during and just after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 clamp in reset", int'(clp), 1);
        check("R10 others in reset", int'({pa, pb, dis, valid, led, tst}), 0);
        check("R10 result in reset", int'(res), 0);
        rst_n = 1'b1;
        repeat (700) @(negedge clk);
        check("R10 clamp held after release", int'(clp), 1);
        check("R3 no phase before first chop", int'({pa, pb}), 0);
    endtask

    // R4/R5/R6/R7/R8: one conversion with a comparator change d clocks
    // after discharge is first seen (or none), plus window checks R1/R2/R3/R9/R11.
    task automatic t_measure(input int d, input bit flip, input string tag);
        int n_dis = 0;
        int exp;
        cyc_idx++;
        exp = flip ? ((d + 4 > 127) ? 127 : d + 4) : 127;
        while (!dis) @(negedge clk);
        check({"R8 led held into conversion ", tag}, int'(led), int'(led_exp));
        while (dis) begin
            n_dis++;
            if (flip && n_dis == d + 1) cmp = ~cmp;
            @(negedge clk);
        end
        check({"R6 discharge width ", tag}, n_dis, exp);
        check({"R3 no phase after discharge ", tag}, int'({pa, pb}), 0);
        while (!valid) @(negedge clk);
        check({"R4 R5 result ", tag}, int'(res), exp);
        led_exp = (exp > 64);
        check({"R8 led ", tag}, int'(led), int'(led_exp));
        @(negedge clk);
        check({"R7 strobe single ", tag}, int'(valid), 0);
        check({"R7 result held ", tag}, int'(res), exp);
        if (cyc_idx >= 2) begin
            check({"R11 period ", tag}, s_per, PERIOD);
            check({"R2 R3 phase a clocks ", tag}, s_a, PHASE_TOT);
            check({"R2 R3 phase b clocks ", tag}, s_b, PHASE_TOT);
            check({"R7 clamp clocks ", tag}, s_clamp, CLAMP_CLKS);
            check({"R9 test clocks ", tag}, s_test, (cyc_idx % 2 == 1) ? PHASE_TOT : 0);
            check({"R9 test outside phase a ", tag}, s_bad, 0);
            check({"R1 overlap ", tag}, s_over, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_measure(0,   1'b1, "d0 rising");
        t_measure(60,  1'b1, "level 64 falling");
        t_measure(61,  1'b1, "level 65 rising");
        t_measure(0,   1'b0, "no edge cap");
        t_measure(122, 1'b1, "d122 falling");
        t_measure(10,  1'b1, "d10 rising");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule